// File: doc/BRIEF.md
# Multi-Mode Timer with Interrupt Vector

This block is a free-running timer with a primary period register (compare 0) and two further compare channels. A count-enable input advances the counter by one step per clock while it is high. A two-bit mode input picks one of four counting behaviours. The behaviours are held, counting up to compare 0, counting through the full range, and counting up to compare 0 and back down to zero. Each of the two further channels drives a waveform pin. The pin is either set by the period event and cleared by its own match, or toggled by its own match. From one period setting this yields independent duty cycles.

Compare 0 has an interrupt line of its own that needs no decoding. The pending flags of channel 1, channel 2 and the counter overflow share a second line. They are presented through an even-valued vector that always reports the highest-priority pending cause. A one-cycle read strobe on the vector retires exactly the cause it reports, so a handler can loop on the vector until it reads zero.

Top module: `mmt_top`

## Requirements
- R1: After reset `count` is 0, both waveform pins are low, both interrupt lines are low and `vec_val` is 0. With `mode_sel` = 2'b00 (stop) the count holds its value.
- R2: With `mode_sel` = 2'b01 (up) each enabled clock adds one. A step taken from a count at or above `cmp0` lands on 0 instead, so the sequence repeats with period `cmp0`+1.
- R3: With `mode_sel` = 2'b10 (continuous) each enabled clock adds one and the count wraps from all ones to 0.
- R4: With `mode_sel` = 2'b11 (up/down) the count climbs from 0 to `cmp0`, then steps down to 0, then climbs again, for a period of 2×`cmp0`.
- R5: `irq_ch0` is high for exactly the one cycle following each step that lands the count on `cmp0`.
- R6: `vec_val` reads 4'h0 with nothing pending, 4'h2 when channel 1 is the highest pending cause, 4'h4 for channel 2 and 4'hA for overflow. Priority is channel 1, then channel 2, then overflow. `irq_vec` is high exactly when `vec_val` is non-zero.
- R7: A cycle with `vec_rd` high clears only the cause that `vec_val` shows in that cycle. The next cause then appears, and a read at 0 changes nothing.
- R8: The overflow cause is raised by the step that wraps the count to 0 in up and continuous modes, and by the step that brings the count down to 0 in up/down mode.
- R9: With `pwm_mode` bit i = 0 (set/reset), waveform pin i goes high on the step that reaches `cmp0` and low on the step that reaches its own compare value. If both happen on the same step, low wins. Bit 0 belongs to `cmp1`, bit 1 to `cmp2`.
- R10: With `pwm_mode` bit i = 1 (toggle), waveform pin i inverts on each step that reaches its own compare value.
- R11: While `cnt_en` is low the count, pins and flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count step enable |
| mode_sel | input | 2 | 00 stop, 01 up, 10 continuous, 11 up/down |
| cmp0 | input | WIDTH | Period / compare 0 value |
| cmp1 | input | WIDTH | Channel 1 compare value |
| cmp2 | input | WIDTH | Channel 2 compare value |
| pwm_mode | input | 2 | Per-channel pin behaviour: 0 set/reset, 1 toggle |
| vec_rd | input | 1 | Vector read strobe, retires the reported cause |
| count | output | WIDTH | Current counter value |
| pwm_out | output | 2 | Waveform pins for channels 1 and 2 |
| irq_ch0 | output | 1 | Dedicated compare-0 request |
| irq_vec | output | 1 | Shared request for channel 1, channel 2 and overflow |
| vec_val | output | 4 | Prioritised interrupt vector |

## Verification
The hardest state to reach from the ports is a vector holding all three causes at once, so that the read strobe's one-at-a-time retirement and the priority order can both be seen. The bench gets there by running continuous mode over a full wrap with both channel compares parked at the top value, and then switching to stop mode so no new events arrive. It then issues reads one by one and expects 4'h2, 4'h4, 4'hA and 0 in turn. The turning points of up/down mode are swept over many period values on a reduced-width instance, because the steps next to a period of 1 are easy to get wrong.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    typedef enum logic [1:0] {
        MODE_STOP = 2'b00,
        MODE_UP   = 2'b01,
        MODE_CONT = 2'b10,
        MODE_UPDN = 2'b11
    } cnt_mode_e;

    typedef enum logic {
        OUT_SETRST = 1'b0,
        OUT_TOGGLE = 1'b1
    } out_mode_e;

    localparam int NUM_CH = 2;
    localparam int VEC_W  = 4;

    localparam logic [VEC_W-1:0] VEC_NONE = 4'h0;
    localparam logic [VEC_W-1:0] VEC_CH1  = 4'h2;
    localparam logic [VEC_W-1:0] VEC_CH2  = 4'h4;
    localparam logic [VEC_W-1:0] VEC_OVF  = 4'hA;

    typedef struct packed {
        logic ovf;
        logic ch2;
        logic ch1;
    } pend_t;

    function automatic logic [VEC_W-1:0] vec_encode(pend_t p);
        if (p.ch1)      return VEC_CH1;
        else if (p.ch2) return VEC_CH2;
        else if (p.ovf) return VEC_OVF;
        else            return VEC_NONE;
    endfunction

    function automatic pend_t top_cause(pend_t p);
        pend_t m;
        m = '0;
        if (p.ch1)      m.ch1 = 1'b1;
        else if (p.ch2) m.ch2 = 1'b1;
        else if (p.ovf) m.ovf = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/mmt_counter.sv
module mmt_counter
    import mmt_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  cnt_mode_e        mode,
    input  logic [WIDTH-1:0] top,
    output logic [WIDTH-1:0] cnt,
    output logic [WIDTH-1:0] nxt,
    output logic             tick,
    output logic             wrap
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ALL = {WIDTH{1'b1}};

    logic dir_down;
    logic dir_nx;

    always_comb begin
        tick   = cnt_en && (mode != MODE_STOP);
        nxt    = cnt;
        wrap   = 1'b0;
        dir_nx = dir_down;
        case (mode)
            MODE_UP: begin
                if (cnt >= top) begin
                    nxt  = '0;
                    wrap = 1'b1;
                end else begin
                    nxt = cnt + ONE;
                end
            end
            MODE_CONT: begin
                nxt  = cnt + ONE;
                wrap = (cnt == ALL);
            end
            MODE_UPDN: begin
                if (dir_down || ((cnt >= top) && (cnt != '0))) begin
                    if (cnt <= ONE) begin
                        nxt    = '0;
                        wrap   = 1'b1;
                        dir_nx = 1'b0;
                    end else begin
                        nxt    = cnt - ONE;
                        dir_nx = 1'b1;
                    end
                end else if (cnt < top) begin
                    nxt = cnt + ONE;
                end
            end
            default: ;
        endcase
        if (!tick) begin
            nxt    = cnt;
            wrap   = 1'b0;
            dir_nx = dir_down;
        end
        if (mode != MODE_UPDN) dir_nx = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            dir_down <= 1'b0;
        end else begin
            cnt      <= nxt;
            dir_down <= dir_nx;
        end
    end

endmodule

// File: rtl/mmt_channel.sv
module mmt_channel
    import mmt_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [WIDTH-1:0] nxt,
    input  logic [WIDTH-1:0] cmp,
    input  logic             period_hit,
    input  out_mode_e        omode,
    output logic             hit,
    output logic             pwm
);
    assign hit = tick && (nxt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm <= 1'b0;
        end else if (omode == OUT_TOGGLE) begin
            if (hit) pwm <= ~pwm;
        end else begin
            if (hit)             pwm <= 1'b0;
            else if (period_hit) pwm <= 1'b1;
        end
    end

endmodule

// File: rtl/mmt_vector.sv
module mmt_vector
    import mmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pend_t            set_ev,
    input  logic             rd,
    output logic [VEC_W-1:0] vec,
    output logic             irq
);
    pend_t pend;
    pend_t clr;

    always_comb begin
        clr = rd ? top_cause(pend) : '0;
        vec = vec_encode(pend);
        irq = |pend;
    end

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr) | set_ev;
    end

endmodule

// File: rtl/mmt_top.sv
module mmt_top
    import mmt_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [1:0]       mode_sel,
    input  logic [WIDTH-1:0] cmp0,
    input  logic [WIDTH-1:0] cmp1,
    input  logic [WIDTH-1:0] cmp2,
    input  logic [1:0]       pwm_mode,
    input  logic             vec_rd,
    output logic [WIDTH-1:0] count,
    output logic [1:0]       pwm_out,
    output logic             irq_ch0,
    output logic             irq_vec,
    output logic [3:0]       vec_val
);
    cnt_mode_e        mode;
    logic [WIDTH-1:0] nxt;
    logic             tick;
    logic             wrap;
    logic             hit0;
    logic [WIDTH-1:0] ch_cmp [NUM_CH];
    logic [NUM_CH-1:0] ch_hit;
    pend_t            set_ev;

    assign mode = cnt_mode_e'(mode_sel);

    mmt_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .cnt_en (cnt_en),
        .mode   (mode),
        .top    (cmp0),
        .cnt    (count),
        .nxt    (nxt),
        .tick   (tick),
        .wrap   (wrap)
    );

    assign hit0 = tick && (nxt == cmp0);

    always_ff @(posedge clk) begin
        if (rst) irq_ch0 <= 1'b0;
        else     irq_ch0 <= hit0;
    end

    assign ch_cmp[0] = cmp1;
    assign ch_cmp[1] = cmp2;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        mmt_channel #(.WIDTH(WIDTH)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .nxt        (nxt),
            .cmp        (ch_cmp[g]),
            .period_hit (hit0),
            .omode      (out_mode_e'(pwm_mode[g])),
            .hit        (ch_hit[g]),
            .pwm        (pwm_out[g])
        );
    end

    assign set_ev = '{ovf: wrap, ch2: ch_hit[1], ch1: ch_hit[0]};

    mmt_vector u_vec (
        .clk    (clk),
        .rst    (rst),
        .set_ev (set_ev),
        .rd     (vec_rd),
        .vec    (vec_val),
        .irq    (irq_vec)
    );

endmodule

// File: rtl/mmt_checker.sv
module mmt_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic [1:0]       mode_sel,
    input logic [WIDTH-1:0] cmp0,
    input logic             vec_rd,
    input logic [WIDTH-1:0] count,
    input logic             irq_ch0,
    input logic             irq_vec,
    input logic [3:0]       vec_val
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    assert_stop_holds_R1: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b00) |=> $stable(count));

    assert_enable_low_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en) |=> $stable(count));

    assert_up_wraps_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && mode_sel == 2'b01 && count >= cmp0) |=> (count == '0));

    assert_period_irq_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && mode_sel == 2'b01 && count < cmp0 && (count + ONE) == cmp0) |=> irq_ch0);

    assert_vec_codes_R6: assert property (@(posedge clk) disable iff (rst)
        (vec_val == 4'h0 || vec_val == 4'h2 || vec_val == 4'h4 || vec_val == 4'hA));

    assert_vec_line_R6: assert property (@(posedge clk) disable iff (rst)
        irq_vec == (vec_val != 4'h0));

    assert_read_retires_R7: assert property (@(posedge clk) disable iff (rst)
        (vec_rd && mode_sel == 2'b00 && vec_val == 4'hA) |=> (vec_val == 4'h0));

endmodule

bind mmt_top mmt_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .mode_sel (mode_sel),
    .cmp0     (cmp0),
    .vec_rd   (vec_rd),
    .count    (count),
    .irq_ch0  (irq_ch0),
    .irq_vec  (irq_vec),
    .vec_val  (vec_val)
);

// File: tb/tb_mmt_top.sv
module tb_mmt_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cnt_en = 1'b0;
    logic [1:0]   mode_sel = 2'b00;
    logic [W-1:0] cmp0 = '0, cmp1 = '1, cmp2 = '1;
    logic [1:0]   pwm_mode = 2'b00;
    logic         vec_rd = 1'b0;
    logic [W-1:0] count;
    logic [1:0]   pwm_out;
    logic         irq_ch0, irq_vec;
    logic [3:0]   vec_val;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mmt_top #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .mode_sel(mode_sel),
        .cmp0(cmp0), .cmp1(cmp1), .cmp2(cmp2), .pwm_mode(pwm_mode),
        .vec_rd(vec_rd), .count(count), .pwm_out(pwm_out),
        .irq_ch0(irq_ch0), .irq_vec(irq_vec), .vec_val(vec_val)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        finish_run();
    end

    initial begin
        int e;
        int p;
        // R1: reset state
        do_reset();
        check("R1 count", int'(count), 0);
        check("R1 pwm", int'(pwm_out), 0);
        check("R1 irq0", int'(irq_ch0), 0);
        check("R1 irqv", int'(irq_vec), 0);
        check("R1 vec", int'(vec_val), 0);

        // R2 / R5 / R8: up-mode sweep of period values
        for (int c = 0; c <= 250; c += 5) begin
            cmp0 = W'(c); cmp1 = '1; cmp2 = '1; mode_sel = 2'b01; cnt_en = 1'b1;
            do_reset();
            for (int n = 1; n <= 2 * (c + 1) + 1; n++) begin
                step();
                e = n % (c + 1);
                check("R2 up count", int'(count), e);
                check("R5 irq0 up", int'(irq_ch0), (e == c) ? 1 : 0);
                check("R8 ovf up", int'(vec_val), (n >= c + 1) ? 10 : 0);
            end
        end

        // R4 / R8: up/down sweep
        for (int c = 1; c <= 250; c += 7) begin
            cmp0 = W'(c); cmp1 = '1; cmp2 = '1; mode_sel = 2'b11; cnt_en = 1'b1;
            do_reset();
            for (int n = 1; n <= 4 * c + 1; n++) begin
                step();
                p = n % (2 * c);
                e = (p <= c) ? p : 2 * c - p;
                check("R4 updown count", int'(count), e);
                check("R5 irq0 updown", int'(irq_ch0), (e == c) ? 1 : 0);
                check("R8 ovf updown", int'(vec_val), (n >= 2 * c) ? 10 : 0);
            end
        end

        // R3 / R6: continuous through a full wrap, channel compares at top
        cmp0 = 8'd100; cmp1 = '1; cmp2 = '1; mode_sel = 2'b10; cnt_en = 1'b1;
        do_reset();
        for (int n = 1; n <= 300; n++) begin
            step();
            e = n % 256;
            check("R3 cont count", int'(count), e);
            check("R5 irq0 cont", int'(irq_ch0), (e == 100) ? 1 : 0);
            check("R6 vec priority", int'(vec_val), (n >= 255) ? 2 : 0);
        end

        // R1 / R7: freeze, then retire causes one at a time
        mode_sel = 2'b00;
        step();
        e = int'(count);
        step();
        check("R1 stop hold", int'(count), e);
        check("R6 irqv", int'(irq_vec), 1);
        vec_rd = 1'b1; step(); vec_rd = 1'b0;
        check("R7 after read 1", int'(vec_val), 4);
        vec_rd = 1'b1; step(); vec_rd = 1'b0;
        check("R7 after read 2", int'(vec_val), 10);
        vec_rd = 1'b1; step(); vec_rd = 1'b0;
        check("R7 after read 3", int'(vec_val), 0);
        check("R6 irqv clear", int'(irq_vec), 0);
        vec_rd = 1'b1; step(); vec_rd = 1'b0;
        check("R7 read at zero", int'(vec_val), 0);
        check("R1 stop hold 2", int'(count), e);

        // R9 / R10: up mode period 10, ch1 set/reset at 3, ch2 toggle at 6
        cmp0 = 8'd9; cmp1 = 8'd3; cmp2 = 8'd6; pwm_mode = 2'b10; mode_sel = 2'b01;
        do_reset();
        for (int n = 1; n <= 40; n++) begin
            step();
            e = n % 10;
            check("R9 setrst pin", int'(pwm_out[0]), (n >= 9 && (e == 9 || e < 3)) ? 1 : 0);
            check("R10 toggle pin", int'(pwm_out[1]), ((n + 4) / 10) % 2);
        end

        // R9: same-step set and reset keeps pin low; ch2 set/reset at 6
        cmp1 = 8'd9; pwm_mode = 2'b00;
        do_reset();
        for (int n = 1; n <= 25; n++) begin
            step();
            e = n % 10;
            check("R9 reset wins", int'(pwm_out[0]), 0);
            check("R9 setrst ch2", int'(pwm_out[1]), (n >= 9 && (e == 9 || e < 6)) ? 1 : 0);
        end

        // R11: enable low freezes everything
        cmp0 = 8'd50; cmp1 = 8'd8; cmp2 = '1; mode_sel = 2'b01;
        do_reset();
        for (int n = 1; n <= 7; n++) step();
        check("R11 pre", int'(count), 7);
        cnt_en = 1'b0;
        for (int n = 1; n <= 5; n++) begin
            step();
            check("R11 hold count", int'(count), 7);
            check("R11 hold vec", int'(vec_val), 0);
        end
        cnt_en = 1'b1;
        step();
        check("R11 resume", int'(count), 8);
        check("R11 resume flag", int'(vec_val), 2);

        finish_run();
    end

endmodule